// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital intake of a three-wire serial DAC. It runs on a fast system clock and treats the four external control pins as asynchronous inputs: the serial clock, the serial data line, an active-low load strobe and an active-low clear. Each pin passes through a two-flop synchroniser. The block detects rising edges of the synchronised serial clock and shifts the data line into an input shift register, most significant bit first. A second register holds the code sent to the converter. While the load strobe is low, the code register follows the shift register. While the clear is low, the code register is held at zero, and the clear wins over the load.

A timing monitor measures each pin event in system-clock cycles. It compares the measurement against minimum pulse widths, setup times and hold times. A parameter picks the limit set for the low-supply or the high-supply corner. The limits are given in nanoseconds and converted to cycles from the clock-period parameter. Any violation sets a sticky per-rule cause bit. A host clear input clears the cause bits. A one-cycle strobe marks every change of the code register.

Top module: `serial_dac_front`

## Requirements
- R1: On each rising edge of the synchronised serial clock, the data bit enters the shift register at bit 0 and the older bits move one place up. After RES_BITS clocks, the first bit received sits in the most significant position.
- R2: RES_BITS selects the width of both the shift register and the code register, as 12 or 10 bits. The 10-bit variant keeps the last 10 bits shifted in.
- R3: While the synchronised load strobe is low and clear is high, the code register takes the shift register value on every cycle.
- R4: While the load strobe is high and clear is high, shifting new bits leaves the code register unchanged.
- R5: While the synchronised clear is low, the code register is zero, whatever the load strobe level.
- R6: During and right after reset, the code is zero, the update strobe is low, the error flag is low and the cause field is zero.
- R7: `code_upd_o` is high for exactly the cycles in which the code register takes a new value, and only in those cycles.
- R8: A serial clock high phase or low phase shorter than the limit sets cause bit 0 or bit 1. The limit is 50 ns at the low-supply corner and 30 ns at the high-supply corner.
- R9: Cause bit 2 is set when the data line has been stable for less than 10 ns before a clock rise. Cause bit 3 is set when the data line changes sooner than the hold limit after a clock rise. The hold limit is 30 ns at the low-supply corner and 15 ns at the high-supply corner.
- R10: Cause bit 4 is set by a load-low pulse shorter than 30 ns at the low-supply corner or 20 ns at the high-supply corner. Cause bit 5 is set by a clear-low pulse shorter than 15 ns.
- R11: Cause bit 6 is set when the load strobe falls sooner than 30 ns (low-supply) or 15 ns (high-supply) after a clock rise. Cause bit 7 is set when a clock rise comes sooner than 40 ns (low-supply) or 20 ns (high-supply) after the load strobe rises.
- R12: Cause bits are sticky. `tv_err_o` is high whenever any cause bit is set. A pulse on `err_clr_i` clears all bits, and the clear takes priority over a violation in the same cycle.
- R13: SUPPLY_HI=1 selects the high-supply limits. At that corner, a 40 ns clock-high phase raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_sclk_i | input | 1 | Serial clock pin (asynchronous) |
| pin_sdi_i | input | 1 | Serial data pin (asynchronous) |
| pin_ld_ni | input | 1 | Load strobe pin, active low, level sensitive |
| pin_clr_ni | input | 1 | Clear pin, active low |
| err_clr_i | input | 1 | Clears the sticky timing-violation cause bits |
| code_o | output | RES_BITS | Parallel DAC code |
| code_upd_o | output | 1 | One-cycle strobe on every change of code_o |
| tv_err_o | output | 1 | Any timing violation has been seen since the last clear |
| tv_cause_o | output | 8 | Sticky per-rule violation bits |

## Verification
The hardest case to reach is the transparent load. The code register then changes once per shifted bit, and it must not change when a shifted bit leaves the shift register value as it was. The stimulus holds the load strobe low across a run of clock pulses. Meanwhile the bench models the register pair and queues one expected code for every change it predicts, so a missing or extra update strobe shows up. The timing rules are each provoked in isolation by shortening one gap to one or two system cycles while keeping every other gap wide. A second instance at the other corner and at 10-bit resolution shares the same pins, so a single clock-high pulse is a violation at one corner and legal at the other.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int RULE_N = 8;

  localparam int RULE_CLK_HI   = 0;
  localparam int RULE_CLK_LO   = 1;
  localparam int RULE_D_SETUP  = 2;
  localparam int RULE_D_HOLD   = 3;
  localparam int RULE_LD_WIDTH = 4;
  localparam int RULE_CL_WIDTH = 5;
  localparam int RULE_LD_SETUP = 6;
  localparam int RULE_LD_HOLD  = 7;

  // pin vector positions after synchronisation
  localparam int PIN_SCLK = 0;
  localparam int PIN_SDI  = 1;
  localparam int PIN_LD   = 2;
  localparam int PIN_CLR  = 3;
  localparam int PIN_N    = 4;

  // minimum time per rule in ns, for the low or high supply corner
  function automatic int rule_ns(int rule, bit supply_hi);
    int ns;
    case (rule)
      RULE_CLK_HI:   ns = supply_hi ? 30 : 50;
      RULE_CLK_LO:   ns = supply_hi ? 30 : 50;
      RULE_D_SETUP:  ns = 10;
      RULE_D_HOLD:   ns = supply_hi ? 15 : 30;
      RULE_LD_WIDTH: ns = supply_hi ? 20 : 30;
      RULE_CL_WIDTH: ns = 15;
      RULE_LD_SETUP: ns = supply_hi ? 15 : 30;
      default:       ns = supply_hi ? 20 : 40;
    endcase
    return ns;
  endfunction

  // round a time up to whole system-clock cycles, at least one
  function automatic int ns_to_cyc(int ns, int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    IDLE_LV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= IDLE_LV;
      stage2_q <= IDLE_LV;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/sdac_pin_events.sv
module sdac_pin_events #(
  parameter int           W       = 4,
  parameter logic [W-1:0] IDLE_LV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_LV;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
    assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/sdac_dbuf.sv
module sdac_dbuf #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdi_i,
  input  logic         ld_n_i,
  input  logic         clr_n_i,
  output logic [N-1:0] sr_o,
  output logic [N-1:0] code_o,
  output logic         upd_o
);

  logic [N-1:0] sr_q,   sr_d;
  logic [N-1:0] code_q, code_d;
  logic         upd_q,  upd_d;
  logic         sr_en,  code_en;

  // next state
  always_comb begin
    sr_en = shift_en_i;
    sr_d  = {sr_q[N-2:0], sdi_i};

    if (!clr_n_i)     code_d = '0;
    else if (!ld_n_i) code_d = sr_q;
    else              code_d = code_q;

    code_en = (code_d != code_q);
    upd_d   = code_en;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (sr_en)   sr_q   <= sr_d;
      if (code_en) code_q <= code_d;
      upd_q <= upd_d;
    end
  end

  assign sr_o   = sr_q;
  assign code_o = code_q;
  assign upd_o  = upd_q;

endmodule

// File: rtl/sdac_tmon.sv
module sdac_tmon
  import sdac_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter bit SUPPLY_HI     = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_N-1:0]  lvl_i,
  input  logic [PIN_N-1:0]  rise_i,
  input  logic [PIN_N-1:0]  fall_i,
  input  logic              err_clr_i,
  output logic [RULE_N-1:0] cause_o,
  output logic              err_o
);

  localparam int MIN_CH  = ns_to_cyc(rule_ns(RULE_CLK_HI,   SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_CL  = ns_to_cyc(rule_ns(RULE_CLK_LO,   SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_DS  = ns_to_cyc(rule_ns(RULE_D_SETUP,  SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_DH  = ns_to_cyc(rule_ns(RULE_D_HOLD,   SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_LDW = ns_to_cyc(rule_ns(RULE_LD_WIDTH, SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_CRW = ns_to_cyc(rule_ns(RULE_CL_WIDTH, SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_LDS = ns_to_cyc(rule_ns(RULE_LD_SETUP, SUPPLY_HI), CLK_PERIOD_NS);
  localparam int MIN_LDH = ns_to_cyc(rule_ns(RULE_LD_HOLD,  SUPPLY_HI), CLK_PERIOD_NS);
  // the widest limit of either corner bounds every counter
  localparam int MAX_CYC = ns_to_cyc(50, CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(MAX_CYC + 2);

  // age counters: cycles since the last event of each kind
  localparam int AGE_CLK_EDGE = 0;
  localparam int AGE_CLK_RISE = 1;
  localparam int AGE_SDI      = 2;
  localparam int AGE_LD       = 3;
  localparam int AGE_CLR      = 4;
  localparam int AGE_N        = 5;

  logic [AGE_N-1:0] age_ev;
  logic [CNT_W-1:0] age_q [AGE_N];
  logic [CNT_W-1:0] age_d [AGE_N];

  assign age_ev[AGE_CLK_EDGE] = rise_i[PIN_SCLK] | fall_i[PIN_SCLK];
  assign age_ev[AGE_CLK_RISE] = rise_i[PIN_SCLK];
  assign age_ev[AGE_SDI]      = rise_i[PIN_SDI]  | fall_i[PIN_SDI];
  assign age_ev[AGE_LD]       = rise_i[PIN_LD]   | fall_i[PIN_LD];
  assign age_ev[AGE_CLR]      = rise_i[PIN_CLR]  | fall_i[PIN_CLR];

  for (genvar g = 0; g < AGE_N; g++) begin : g_age
    always_comb begin
      if (age_ev[g])            age_d[g] = '0;
      else if (&age_q[g])       age_d[g] = age_q[g];
      else                      age_d[g] = age_q[g] + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q[g] <= '1;
      else         age_q[g] <= age_d[g];
    end
  end

  // gap in cycles between the last event and this one is age + 1
  function automatic logic too_short(logic [CNT_W-1:0] age, int min_cyc);
    return (int'(age) + 1) < min_cyc;
  endfunction

  logic [RULE_N-1:0] viol;
  logic              sdi_chg;

  always_comb begin
    sdi_chg = age_ev[AGE_SDI];
    viol    = '0;
    viol[RULE_CLK_HI]   = fall_i[PIN_SCLK] && too_short(age_q[AGE_CLK_EDGE], MIN_CH);
    viol[RULE_CLK_LO]   = rise_i[PIN_SCLK] && too_short(age_q[AGE_CLK_EDGE], MIN_CL);
    viol[RULE_D_SETUP]  = rise_i[PIN_SCLK] && (sdi_chg || too_short(age_q[AGE_SDI], MIN_DS));
    viol[RULE_D_HOLD]   = sdi_chg && !rise_i[PIN_SCLK] &&
                          too_short(age_q[AGE_CLK_RISE], MIN_DH);
    viol[RULE_LD_WIDTH] = rise_i[PIN_LD]  && too_short(age_q[AGE_LD], MIN_LDW);
    viol[RULE_CL_WIDTH] = rise_i[PIN_CLR] && too_short(age_q[AGE_CLR], MIN_CRW);
    viol[RULE_LD_SETUP] = fall_i[PIN_LD]  && too_short(age_q[AGE_CLK_RISE], MIN_LDS);
    viol[RULE_LD_HOLD]  = rise_i[PIN_SCLK] && lvl_i[PIN_LD] &&
                          too_short(age_q[AGE_LD], MIN_LDH);
  end

  // sticky cause bits, host clear wins
  logic [RULE_N-1:0] cause_q, cause_d;
  logic              cause_en;

  always_comb begin
    cause_en = err_clr_i || (|viol);
    cause_d  = err_clr_i ? '0 : (cause_q | viol);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign err_o   = |cause_q;

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import sdac_pkg::*;
#(
  parameter int RES_BITS      = 12,
  parameter int CLK_PERIOD_NS = 10,
  parameter bit SUPPLY_HI     = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_sclk_i,
  input  logic                pin_sdi_i,
  input  logic                pin_ld_ni,
  input  logic                pin_clr_ni,
  input  logic                err_clr_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                code_upd_o,
  output logic                tv_err_o,
  output logic [RULE_N-1:0]   tv_cause_o
);

  // idle pin levels: clock low, data low, load high, clear high
  localparam logic [PIN_N-1:0] IDLE_LV = PIN_N'((1 << PIN_LD) | (1 << PIN_CLR));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  logic [PIN_N-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;

  assign pin_raw[PIN_SCLK] = pin_sclk_i;
  assign pin_raw[PIN_SDI]  = pin_sdi_i;
  assign pin_raw[PIN_LD]   = pin_ld_ni;
  assign pin_raw[PIN_CLR]  = pin_clr_ni;

  sdac_sync #(.W(PIN_N), .IDLE_LV(IDLE_LV)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .async_i (pin_raw),
    .sync_o  (pin_lvl)
  );

  sdac_pin_events #(.W(PIN_N), .IDLE_LV(IDLE_LV)) u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .lvl_i  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  logic [RES_BITS-1:0] shift_q;

  sdac_dbuf #(.N(RES_BITS)) u_dbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .shift_en_i (pin_rise[PIN_SCLK]),
    .sdi_i      (pin_lvl[PIN_SDI]),
    .ld_n_i     (pin_lvl[PIN_LD]),
    .clr_n_i    (pin_lvl[PIN_CLR]),
    .sr_o       (shift_q),
    .code_o     (code_o),
    .upd_o      (code_upd_o)
  );

  sdac_tmon #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .SUPPLY_HI(SUPPLY_HI)) u_tmon (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .lvl_i     (pin_lvl),
    .rise_i    (pin_rise),
    .fall_i    (pin_fall),
    .err_clr_i (err_clr_i),
    .cause_o   (tv_cause_o),
    .err_o     (tv_err_o)
  );

endmodule

// File: rtl/serial_dac_front_chk.sv
module serial_dac_front_chk #(
  parameter int N = 12
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         clr_n_s,
  input logic         ld_n_s,
  input logic [N-1:0] sr,
  input logic [N-1:0] code,
  input logic         upd,
  input logic         err,
  input logic [7:0]   cause,
  input logic         err_clr
);

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clr_n_s |=> (code == '0)); // R5

  AST_LOAD_FOLLOWS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_n_s && !ld_n_s) |=> (code == $past(sr))); // R3

  AST_CODE_HELD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_n_s && ld_n_s) |=> $stable(code)); // R4

  AST_UPD_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code != $past(code)) |-> upd); // R7

  AST_UPD_ONLY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    upd |-> (code != $past(code))); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err && !err_clr) |=> err); // R12

  AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_clr |=> (cause == '0)); // R12

endmodule

bind serial_dac_front serial_dac_front_chk #(.N(RES_BITS)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_sync),
  .clr_n_s (pin_lvl[sdac_pkg::PIN_CLR]),
  .ld_n_s  (pin_lvl[sdac_pkg::PIN_LD]),
  .sr      (shift_q),
  .code    (code_o),
  .upd     (code_upd_o),
  .err     (tv_err_o),
  .cause   (tv_cause_o),
  .err_clr (err_clr_i)
);

// File: tb/serial_dac_front_tb_top.sv
module serial_dac_front_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1, errclr = 1'b0;

  logic [11:0] code;
  logic        upd, err;
  logic [7:0]  cause;
  logic [9:0]  code5;
  logic        upd5, err5;
  logic [7:0]  cause5;

  int nchk = 0;
  int nerr = 0;

  logic [11:0] exp_sr   = '0;
  logic [11:0] exp_code = '0;
  logic [11:0] exp_q [$];

  always #5 clk = ~clk;

  serial_dac_front #(.RES_BITS(12), .CLK_PERIOD_NS(10), .SUPPLY_HI(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_sclk_i(sclk), .pin_sdi_i(sdi),
    .pin_ld_ni(ld_n), .pin_clr_ni(clr_n), .err_clr_i(errclr),
    .code_o(code), .code_upd_o(upd), .tv_err_o(err), .tv_cause_o(cause)
  );

  serial_dac_front #(.RES_BITS(10), .CLK_PERIOD_NS(10), .SUPPLY_HI(1'b1)) dut5_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_sclk_i(sclk), .pin_sdi_i(sdi),
    .pin_ld_ni(ld_n), .pin_clr_ni(clr_n), .err_clr_i(errclr),
    .code_o(code5), .code_upd_o(upd5), .tv_err_o(err5), .tv_cause_o(cause5)
  );

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // predicted code register; queue one item per predicted change
  task automatic model();
    logic [11:0] tgt;
    if (!clr_n)     tgt = '0;
    else if (!ld_n) tgt = exp_sr;
    else            tgt = exp_code;
    if (tgt != exp_code) begin
      exp_q.push_back(tgt);
      exp_code = tgt;
    end
  endtask

  task automatic rise_clk();
    sclk = 1'b1;
    exp_sr = {exp_sr[10:0], sdi};
    model();
  endtask

  task automatic shift_bit(logic b);
    sdi = b; hold(3);
    rise_clk(); hold(6);
    sclk = 1'b0; hold(6);
  endtask

  task automatic shift_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic set_ld(logic v);   ld_n = v;  model(); endtask
  task automatic set_clr(logic v);  clr_n = v; model(); endtask

  task automatic ld_pulse();
    set_ld(1'b0); hold(5); set_ld(1'b1); hold(6);
  endtask

  task automatic clear_err();
    errclr = 1'b1; hold(1); errclr = 1'b0; hold(3);
  endtask

  task automatic expect_viol(string tag, int bitpos);
    hold(8);
    check({tag, " cause"}, cause, 32'(1 << bitpos));
    hold(10);
    check("R12 sticky", err, 1);
    clear_err();
    check("R12 cleared", {err, cause}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && upd) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nerr++;
        $display("FAIL R7 unexpected update actual=%0h expected=none", code);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        if (code !== e) begin
          nerr++;
          $display("FAIL R7 update value actual=%0h expected=%0h", code, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    hold(3);
    check("R6 code in reset", code, 0);
    check("R6 flags in reset", {upd, err, cause}, 0);
    rst_n = 1'b1;
    hold(6);
    check("R6 code after reset", {code5, code}, 0);
    check("R6 flags after reset", {upd, err, cause, err5, cause5}, 0);

    // R1 R4: shift with load high, code stays
    shift_word(12'hA5C);
    hold(4);
    check("R4 code held while shifting", code, 0);
    ld_pulse();
    check("R1 R3 msb-first load", code, 12'hA5C);
    check("R2 ten-bit variant", code5, 10'h25C);

    shift_word(12'h3F0);
    hold(4);
    check("R4 double buffer", code, 12'hA5C);

    // R5 clear, then clear beats load
    set_clr(1'b0); hold(4); set_clr(1'b1); hold(6);
    check("R5 clear to zero", code, 0);
    set_clr(1'b0); hold(2); set_ld(1'b0); hold(6);
    check("R5 clear over load", code, 0);
    set_clr(1'b1); hold(6);
    check("R3 load after clear release", code, 12'h3F0);
    set_ld(1'b1); hold(4);

    // R3 transparent load across shifting
    set_ld(1'b0); hold(5);
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1);
    set_ld(1'b1); hold(6);
    check("R3 transparent follow", code, exp_sr);
    check("R2 ten-bit transparent", code5, exp_sr[9:0]);
    check("R8 R9 R10 R11 no false flag", {err, cause, err5}, 0);

    // R8 R13: 4-cycle high phase
    sdi = 1'b1; hold(3); rise_clk(); hold(4); sclk = 1'b0; hold(8);
    check("R13 high corner accepts 40ns", cause5[0], 0);
    expect_viol("R8 clock high", 0);

    // R8: short low phase
    hold(3); rise_clk(); hold(6); sclk = 1'b0; hold(2);
    rise_clk(); hold(6); sclk = 1'b0;
    expect_viol("R8 clock low", 1);

    // R9: data change with clock rise
    sdi = 1'b0; rise_clk(); hold(6); sclk = 1'b0;
    expect_viol("R9 data setup", 2);

    // R9: data change one cycle after rise
    sdi = 1'b1; hold(3); rise_clk(); hold(1); sdi = 1'b0; hold(5); sclk = 1'b0;
    expect_viol("R9 data hold", 3);

    // R10: narrow load and clear pulses
    set_ld(1'b0); hold(1); set_ld(1'b1);
    expect_viol("R10 load width", 4);
    set_clr(1'b0); hold(1); set_clr(1'b1);
    expect_viol("R10 clear width", 5);

    // R11: load falls one cycle after rise
    sdi = 1'b1; hold(3); rise_clk(); hold(1);
    set_ld(1'b0); hold(5); set_ld(1'b1); hold(2); sclk = 1'b0;
    expect_viol("R11 load setup", 6);

    // R11: rise one cycle after load rises
    set_ld(1'b0); hold(5); set_ld(1'b1); hold(1);
    rise_clk(); hold(6); sclk = 1'b0;
    expect_viol("R11 load hold", 7);

    check("R1 final code", code, exp_code);
    hold(10);
    check("R7 all updates seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule